// File: doc/BRIEF.md
# Byte-to-Halfword Unaligned Write Packer

This block takes one byte-addressed write request (a start address of any alignment and a byte count) and turns it into a sequence of aligned 16-bit halfword program requests for a downstream engine that can only program whole halfwords. The source bytes arrive one at a time over a valid/ready stream. The block packs them little-endian and hands each finished halfword, with its even address, to the engine.

A halfword may be only partly covered by the request. This happens to the leading halfword of an odd start address and to a trailing single byte. For such a halfword the block first reads the current halfword at the aligned address and keeps the untouched lane. It then merges in the new byte and writes the whole halfword. The engine answers each write with a status. Zero means success. Any other value stops the transfer at once and is reported as the transfer's result.

A transfer starts with a one-cycle `start` pulse while the block is idle. `busy` stays high until the one-cycle `done` pulse. `status` then holds the result until the next transfer ends.

Top module: `halfword_write_packer`

## Requirements
- R1: Every program request carries an even address. The first one is the start address with bit 0 cleared, and each later one is 2 above the one before.
- R2: For an odd start address with a nonzero count, the block issues one read to the aligned address before the first write. That write carries the read data's bits 7:0 in bits 7:0 and the first source byte in bits 15:8.
- R3: For an odd start address with a zero count, the block consumes no source byte and performs one read. It then performs one write of the read data unchanged, and finishes with status 0.
- R4: Each pair of source bytes is packed little-endian: the earlier byte goes to bits 7:0 and the later byte to bits 15:8.
- R5: A single trailing byte goes to bits 7:0 of the last write. Bits 15:8 of that write come from a read of that aligned address issued just before it.
- R6: A zero count at an even address issues no read and no write. `done` rises one cycle after `start`, with status 0.
- R7: A nonzero write status ends the transfer in the cycle after its acknowledge. `done` pulses and `status` equals that value. No further source byte, read or write follows.
- R8: A read or write request holds its address and data unchanged until acknowledged. A read request and a write request are never high together.
- R9: The number of reads equals the number of halfwords with an untouched lane. The number of writes equals the number of halfwords the request spans. A request that spans no halfword causes no write.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running transfer.
- R11: `done` is a one-cycle pulse after which `busy` is low. A successful transfer reports status 0 and consumes exactly the requested number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | AW | Byte start address |
| byte_count | input | CW | Number of bytes to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | SW | Result of the last transfer, 0 = success |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block takes the source byte this cycle |
| rd_req | output | 1 | Readback request |
| rd_addr | output | AW | Aligned readback address |
| rd_ack | input | 1 | Readback complete, rd_data valid |
| rd_data | input | 16 | Current halfword content |
| wr_req | output | 1 | Halfword program request |
| wr_addr | output | AW | Aligned program address |
| wr_data | output | 16 | Halfword to program |
| wr_ack | input | 1 | Program complete, wr_status valid |
| wr_status | input | SW | Program result, 0 = success |

## Verification
Two functions can fall in the same cycle. One is the acknowledge of a write that ends the transfer, either with an error status or as the last halfword. The other is the stream of source bytes and new starts that keeps arriving around it. The bench drives `src_valid` and random `start` pulses freely while writes are being acknowledged. It injects a nonzero status on a chosen write and judges the result by the number of bytes consumed, the number of writes seen and the reported status. It also pulses `start` in the middle of a running transfer and confirms that the final memory image and the request counts match only the first request.

// File: rtl/hwp_pkg.sv
// Shared types for the halfword write packer.
// Assumes a 16-bit program unit made of two 8-bit lanes.
package hwp_pkg;
    localparam int LANE_W = 8;
    localparam int HW_W   = 2 * LANE_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_READ,
        S_LO,
        S_HI,
        S_WRITE,
        S_DONE
    } pk_state_t;

    // Which lanes of the current halfword take new source bytes.
    typedef struct packed {
        logic lo_new;
        logic hi_new;
        logic need_read;
    } lane_plan_t;
endpackage

// File: rtl/hwp_lane_plan.sv
// Decides which lanes of the next halfword are fed by source bytes.
// Assumes rem is the count of source bytes not yet consumed. The head
// halfword of an odd start has its low lane kept from memory.
module hwp_lane_plan
    import hwp_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          first,
    input  logic          odd,
    input  logic [CW-1:0] rem,
    output lane_plan_t    plan
);
    logic head_odd;
    assign head_odd = first && odd;

    // Lane assignment for the halfword about to be built.
    always_comb begin
        plan.lo_new    = !head_odd && (rem != '0);
        plan.hi_new    = head_odd ? (rem != '0) : (rem >= CW'(2));
        plan.need_read = !(plan.lo_new && plan.hi_new);
    end
endmodule

// File: rtl/hwp_merge_buf.sv
// Halfword assembly register: loaded whole from a readback, then
// overwritten lane by lane with source bytes.
// Assumes at most one load strobe is active per cycle.
module hwp_merge_buf
    import hwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_all,
    input  logic [HW_W-1:0]   all_data,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [LANE_W-1:0] byte_in,
    output logic [HW_W-1:0]   word
);
    // Hold and update the halfword being assembled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (load_all) begin
            word <= all_data;
        end else begin
            if (load_lo) word[LANE_W-1:0]    <= byte_in;
            if (load_hi) word[HW_W-1:LANE_W] <= byte_in;
        end
    end
endmodule

// File: rtl/halfword_write_packer.sv
// Top of the packer. Walks a byte-addressed write as aligned halfwords.
// For each halfword it reads back the current content when a lane is
// untouched, collects the new bytes, issues the program request and
// stops on the first nonzero status.
// Assumes the downstream read and write ports answer each held request
// with a one-cycle acknowledge, with rd_data/wr_status valid alongside it.
module halfword_write_packer
    import hwp_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int SW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [CW-1:0]     byte_count,
    output logic              busy,
    output logic              done,
    output logic [SW-1:0]     status,
    input  logic              src_valid,
    input  logic [LANE_W-1:0] src_data,
    output logic              src_ready,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [HW_W-1:0]   rd_data,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [HW_W-1:0]   wr_data,
    input  logic              wr_ack,
    input  logic [SW-1:0]     wr_status
);
    localparam logic [AW-1:0] STEP = AW'(2);

    pk_state_t     state;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] rem;
    logic          odd, first;
    lane_plan_t    plan_now, plan_q;
    logic          take;

    hwp_lane_plan #(.CW(CW)) u_plan (
        .first (first),
        .odd   (odd),
        .rem   (rem),
        .plan  (plan_now)
    );

    assign take = src_ready && src_valid;

    hwp_merge_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_all (state == S_READ && rd_ack),
        .all_data (rd_data),
        .load_lo  (state == S_LO && take),
        .load_hi  (state == S_HI && take),
        .byte_in  (src_data),
        .word     (wr_data)
    );

    // Port views of the controller state.
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);
    assign src_ready = (state == S_LO) || (state == S_HI);
    assign rd_req    = (state == S_READ);
    assign wr_req    = (state == S_WRITE);
    assign rd_addr   = cur_addr;
    assign wr_addr   = cur_addr;

    // Transfer sequencing: plan, readback, byte collection, program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            odd      <= 1'b0;
            first    <= 1'b0;
            plan_q   <= '0;
            status   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    cur_addr <= {start_addr[AW-1:1], 1'b0};
                    rem      <= byte_count;
                    odd      <= start_addr[0];
                    first    <= 1'b1;
                    if (byte_count == '0 && !start_addr[0]) begin
                        status <= '0;
                        state  <= S_DONE;
                    end else begin
                        state  <= S_PLAN;
                    end
                end
                S_PLAN: begin
                    plan_q <= plan_now;
                    if (plan_now.need_read)   state <= S_READ;
                    else                      state <= S_LO;
                end
                S_READ: if (rd_ack) begin
                    if (plan_q.lo_new)        state <= S_LO;
                    else if (plan_q.hi_new)   state <= S_HI;
                    else                      state <= S_WRITE;
                end
                S_LO: if (take) begin
                    rem <= rem - CW'(1);
                    state <= plan_q.hi_new ? S_HI : S_WRITE;
                end
                S_HI: if (take) begin
                    rem   <= rem - CW'(1);
                    state <= S_WRITE;
                end
                S_WRITE: if (wr_ack) begin
                    if (wr_status != '0) begin
                        status <= wr_status;
                        state  <= S_DONE;
                    end else begin
                        cur_addr <= cur_addr + STEP;
                        first    <= 1'b0;
                        if (rem == '0) begin
                            status <= '0;
                            state  <= S_DONE;
                        end else begin
                            state  <= S_PLAN;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// Protocol checker for the packer, attached by bind below.
module hwp_checker #(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [SW-1:0] status,
    input logic          src_ready,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [15:0]   wr_data,
    input logic          wr_ack,
    input logic [SW-1:0] wr_status
);
    // R1: program and read addresses are always halfword aligned.
    a_r1_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !wr_addr[0]);
    a_r1_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !rd_addr[0]);
    // R8: requests are exclusive and hold steady until acknowledged.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    // R7: an error status ends the transfer next cycle and is reported.
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_status != '0) |=> (done && status == $past(wr_status)));
    a_r7_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!src_ready && !rd_req && !wr_req));
    // R11: done is a single pulse followed by idle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind halfword_write_packer hwp_checker #(.AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .src_ready (src_ready),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .wr_status (wr_status)
);

// File: tb/halfword_write_packer_tb.sv
// Bench: memory model answers reads and writes with random latency; a
// byte stream feeds the block with random gaps; results are compared to
// an expected memory image and counts computed here.
module halfword_write_packer_tb;
    localparam int AW = 16;
    localparam int CW = 12;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic busy, done, src_ready, rd_req, wr_req;
    logic [SW-1:0] status;
    logic src_valid = 1'b0;
    logic [7:0] src_data = '0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic rd_ack = 1'b0, wr_ack = 1'b0;
    logic [15:0] rd_data = '0, wr_data;
    logic [SW-1:0] wr_status = '0;

    always #10 clk = ~clk;

    halfword_write_packer #(.AW(AW), .CW(CW), .SW(SW)) u_dut (.*);

    logic [15:0] mem [0:127];
    logic [15:0] exp_mem [0:127];
    logic [7:0]  src_buf [0:63];
    int src_idx, rd_cnt, wr_cnt, err_at, cycles;
    int checks = 0, bad = 0;
    logic [SW-1:0] err_val;
    logic [AW-1:0] exp_next;
    logic hs_seen = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_writes(input int a, input int c);
        if (c == 0) return (a % 2 == 1) ? 1 : 0;
        return ((a + c - 1) / 2) - (a / 2) + 1;
    endfunction

    function automatic int exp_reads(input int a, input int c);
        return (a % 2) + ((c > 0 && ((a + c) % 2 == 1)) ? 1 : 0);
    endfunction

    always @(posedge clk) hs_seen <= src_valid && src_ready;

    // Downstream and source models, all driven away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (hs_seen) src_idx++;
        src_valid = ($urandom % 4) != 0;
        src_data  = src_buf[src_idx % 64];
        rd_ack = 1'b0;
        wr_ack = 1'b0;
        wr_status = '0;
        if (rd_req && ($urandom % 3 != 0)) begin
            rd_ack  = 1'b1;
            rd_data = mem[rd_addr[7:1]];
            rd_cnt++;
        end
        if (wr_req && ($urandom % 3 != 0)) begin
            wr_ack = 1'b1;
            check(wr_addr == exp_next, "R1 write address", int'(wr_addr), int'(exp_next));
            exp_next = exp_next + 2;
            wr_status = (wr_cnt == err_at) ? err_val : '0;
            mem[wr_addr[7:1]] = wr_data;
            wr_cnt++;
        end
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Run one transfer; err_pos < 0 means no injected error.
    task automatic run(input int a, input int c, input int err_pos, input int ev, input bit poke);
        int t;
        int consumed_exp;
        for (int i = 0; i < 128; i++) begin
            mem[i] = 16'($urandom);
            exp_mem[i] = mem[i];
        end
        for (int i = 0; i < 64; i++) src_buf[i] = 8'($urandom);
        for (int i = 0; i < c; i++) begin
            int b = a + i;
            if (b % 2 == 0) exp_mem[b/2][7:0]  = src_buf[i];
            else            exp_mem[b/2][15:8] = src_buf[i];
        end
        src_idx = 0; rd_cnt = 0; wr_cnt = 0;
        err_at = err_pos; err_val = SW'(ev);
        exp_next = AW'(a & ~1);
        @(negedge clk);
        start = 1'b1; start_addr = AW'(a); byte_count = CW'(c);
        @(negedge clk);
        start = 1'b0;
        t = 1;
        while (!done && t < 4000) begin
            if (poke && t == 3) begin
                start = 1'b1; start_addr = AW'(100); byte_count = CW'(3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(done, "R11 done seen", int'(done), 1);
        if (err_pos < 0) begin
            check(status == 0, "R11 status ok", int'(status), 0);
            check(src_idx == c, "R11 bytes consumed", src_idx, c);
            check(wr_cnt == exp_writes(a, c), "R9 write count", wr_cnt, exp_writes(a, c));
            check(rd_cnt == exp_reads(a, c), "R9 R2 R5 read count", rd_cnt, exp_reads(a, c));
            for (int i = 0; i < 128; i++)
                check(mem[i] == exp_mem[i], "R2 R3 R4 R5 memory image", int'(mem[i]), int'(exp_mem[i]));
        end else begin
            consumed_exp = (a & ~1) + 2 * (err_pos + 1) - a;
            if (consumed_exp > c) consumed_exp = c;
            check(status == SW'(ev), "R7 error status", int'(status), ev);
            check(wr_cnt == err_pos + 1, "R7 writes stop", wr_cnt, err_pos + 1);
            check(src_idx == consumed_exp, "R7 bytes stop", src_idx, consumed_exp);
        end
        @(negedge clk);
        check(!done && !busy, "R11 done one cycle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        err_at = -1;
        cycles = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !src_ready && !rd_req && !wr_req, "reset outputs idle",
              int'({busy, done, src_ready, rd_req, wr_req}), 0);
        rst_n = 1'b1;
        // R6: even zero-length finishes in one cycle with no traffic.
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; start_addr = AW'(8); byte_count = '0;
        @(negedge clk);
        start = 1'b0;
        check(done && status == 0, "R6 immediate done", int'(done), 1);
        @(negedge clk);
        check(rd_cnt == 0 && wr_cnt == 0, "R6 no requests", rd_cnt + wr_cnt, 0);
        // Directed corners.
        run(7, 0, -1, 0, 1'b0);   // R3
        run(9, 1, -1, 0, 1'b0);   // R2
        run(12, 1, -1, 0, 1'b0);  // R5
        run(21, 2, -1, 0, 1'b0);  // R2 R5
        run(40, 8, -1, 0, 1'b0);  // R4
        run(51, 6, -1, 0, 1'b0);  // R2 R4
        run(10, 6, -1, 0, 1'b1);  // R10 start while busy
        run(33, 9, 0, 5, 1'b0);   // R7 first write
        run(60, 10, 2, 9, 1'b0);  // R7 mid transfer
        run(3, 7, 3, 1, 1'b0);    // R7 on tail write
        // Random transfers.
        for (int k = 0; k < 40; k++) begin
            int a = $urandom % 200;
            int c = $urandom % 41;
            if (k % 5 == 4 && exp_writes(a, c) > 0)
                run(a, c, $urandom % exp_writes(a, c), 1 + $urandom % 15, 1'b0);
            else
                run(a, c, -1, 0, 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule